// File: doc/BRIEF.md
# Per-Block Flash Write-Protection Manager

This block holds the write-protection state of every erase block in a 135-block flash array with 22-bit word addresses. The array has eight small parameter blocks of 4K words and 127 large main blocks of 32K words. A parameter chooses a top-boot layout, with the parameter blocks in the highest 32K-word slot, or a bottom-boot layout, with them in the lowest slot. Blocks are numbered from 0 at word address 0 upward.

A command decoder upstream presents lock, unlock and lock-down requests, each with a word address inside the target block. The block also watches a hardware protect pin (active low) and a global programming-voltage-OK flag. It answers two questions at any time. The first is whether a program or erase may proceed at a checked address; a refusal is how the error is reported. The second is the two-bit protection status of the block that holds a status address.

Protection works on three levels. There is a software lock bit. There is a lock-down bit, which software can set but only reset can clear, and which the protect pin enforces. There is a global voltage lockout that refuses every block.

Top module: `flk_lockmgr`

## Requirements
- R1: While reset is low, and on release from it, every block reads status 2'b01 and is refused, including blocks that were locked down before the reset.
- R2: Status bit 0 is the lock bit and bit 1 is the lock-down bit. With cmdValid high, op 1 sets the lock bit and op 2 clears it; op 0 does nothing. The change is visible from the cycle after the command.
- R3: Op 3 (lock-down) sets both the lock-down bit and the lock bit of the addressed block.
- R4: No command ever clears a lock-down bit; only reset does.
- R5: While guardN is low, any command to a block whose lock-down bit is set leaves both of its bits unchanged.
- R6: While guardN is high, a block whose lock-down bit is set can be unlocked and relocked with ops 2 and 1.
- R7: chkAllow is high only when the checked block's lock bit is clear and it is not the case that its lock-down bit is set while guardN is low. After guardN returns low, every locked-down block is refused, whatever its lock bit is.
- R8: While vppOk is low, chkAllow is low for every address.
- R9: With the default top-boot layout, word addresses 0x000000 to 0x3F7FFF form main blocks 0 to 126 of 32K words each. Addresses 0x3F8000 to 0x3FFFFF form parameter blocks 127 to 134 of 4K words each. A command changes only the block that holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| cmdValid | input | 1 | Protection command present this cycle |
| cmdOp | input | 2 | 0 none, 1 lock, 2 unlock, 3 lock-down |
| cmdAddr | input | 22 | Word address inside the target block |
| guardN | input | 1 | Hardware protect pin; low enforces lock-down |
| vppOk | input | 1 | Programming voltage above the lockout level |
| chkAddr | input | 22 | Address of the intended program or erase |
| chkAllow | output | 1 | High when program or erase is permitted there |
| statAddr | input | 22 | Address whose block status is read |
| statBits | output | 2 | {lock-down bit, lock bit} of that block |

## Verification
The bench targets the lock-down corner cases. An unlock sent while the pin is low must not move a frozen block; a design that gated only on the lock bit would unlock it. A block unlocked while the pin was high must be refused once the pin falls again; a design that stored the pin's effect in the lock bit instead of combining it at read time would let that block be programmed. It also probes the slot boundaries between the last main block and the first parameter block, where an off-by-one index decoder would unlock the wrong neighbour. It checks that reset wipes lock-down state, which a design holding that bit outside reset would keep.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_DOWN   = 2'd3
  } lk_op_e;

  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setDown;
  } lk_strb_t;
endpackage

// File: rtl/flk_blkmap.sv
module flk_blkmap #(
  parameter int ADDR_W      = 22,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter bit TOP_BOOT    = 1'b1,
  parameter int IDX_W       = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int SLOT_W = ADDR_W - MAIN_SHIFT;
  localparam int SUB_W  = MAIN_SHIFT - PARAM_SHIFT;

  logic [SLOT_W-1:0] slot;
  logic [SUB_W-1:0]  sub;

  assign slot = addr[ADDR_W-1:MAIN_SHIFT];
  assign sub  = addr[MAIN_SHIFT-1:PARAM_SHIFT];

  generate
    if (TOP_BOOT) begin : g_top
      // highest slot is split into small blocks
      always_comb begin
        if (slot == {SLOT_W{1'b1}}) idx = IDX_W'(slot) + IDX_W'(sub);
        else                        idx = IDX_W'(slot);
      end
    end else begin : g_bottom
      // lowest slot is split into small blocks
      always_comb begin
        if (slot == '0) idx = IDX_W'(sub);
        else            idx = IDX_W'(slot) + IDX_W'((2 ** SUB_W) - 1);
      end
    end
  endgenerate
endmodule

// File: rtl/flk_cmdctl.sv
module flk_cmdctl
  import flk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output lk_strb_t   strb
);
  lk_op_e opCode;
  assign opCode = lk_op_e'(cmdOp);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      unique case (opCode)
        OP_LOCK:   strb.setLock = 1'b1;
        OP_UNLOCK: strb.clrLock = 1'b1;
        OP_DOWN:   strb.setDown = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setLock, strb.clrLock, strb.setDown}));

  // R2
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strb == '0));
endmodule

// File: rtl/flk_state.sv
module flk_state
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 135,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  lk_strb_t         strb,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic             guardN,
  input  logic             vppOk,
  input  logic [IDX_W-1:0] chkIdx,
  input  logic [IDX_W-1:0] statIdx,
  output logic             chkAllow,
  output logic [1:0]       statBits
);
  logic [NUM_BLOCKS-1:0] lockQ;
  logic [NUM_BLOCKS-1:0] downQ;
  logic strbAny;
  logic frozenCmd;

  assign strbAny   = strb.setLock | strb.clrLock | strb.setDown;
  assign frozenCmd = downQ[cmdIdx] & ~guardN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '1;
      downQ <= '0;
    end else if (strbAny && !frozenCmd) begin
      if (strb.setLock || strb.setDown) lockQ[cmdIdx] <= 1'b1;
      if (strb.clrLock)                 lockQ[cmdIdx] <= 1'b0;
      if (strb.setDown)                 downQ[cmdIdx] <= 1'b1;
    end
  end

  assign chkAllow = vppOk & ~lockQ[chkIdx] & ~(downQ[chkIdx] & ~guardN);
  assign statBits = {downQ[statIdx], lockQ[statIdx]};

  // R3
  down_sets_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setDown && !frozenCmd) |=> (lockQ[$past(cmdIdx)] && downQ[$past(cmdIdx)]));

  // R4
  down_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbAny |=> ((~downQ & $past(downQ)) == '0));

  // R5
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strbAny && frozenCmd) |=> ($stable(lockQ) && $stable(downQ)));

  // R2
  unlock_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLock && !frozenCmd) |=> !lockQ[$past(cmdIdx)]);
endmodule

// File: rtl/flk_lockmgr.sv
module flk_lockmgr
  import flk_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter bit TOP_BOOT    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              guardN,
  input  logic              vppOk,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic              chkAllow,
  input  logic [ADDR_W-1:0] statAddr,
  output logic [1:0]        statBits
);
  localparam int NUM_BLOCKS = (2 ** (ADDR_W - MAIN_SHIFT)) - 1 + (2 ** (MAIN_SHIFT - PARAM_SHIFT));
  localparam int IDX_W      = $clog2(NUM_BLOCKS);

  lk_strb_t         strb;
  logic [IDX_W-1:0] cmdIdx;
  logic [IDX_W-1:0] chkIdx;
  logic [IDX_W-1:0] statIdx;

  flk_blkmap #(.ADDR_W(ADDR_W), .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT),
               .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    u_mapCmd (.addr(cmdAddr), .idx(cmdIdx));
  flk_blkmap #(.ADDR_W(ADDR_W), .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT),
               .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    u_mapChk (.addr(chkAddr), .idx(chkIdx));
  flk_blkmap #(.ADDR_W(ADDR_W), .PARAM_SHIFT(PARAM_SHIFT), .MAIN_SHIFT(MAIN_SHIFT),
               .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    u_mapStat (.addr(statAddr), .idx(statIdx));

  flk_cmdctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .strb(strb)
  );

  flk_state #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIdx(cmdIdx), .guardN(guardN),
    .vppOk(vppOk), .chkIdx(chkIdx), .statIdx(statIdx),
    .chkAllow(chkAllow), .statBits(statBits)
  );

  // R8
  vpp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vppOk |-> !chkAllow);

  // R7
  same_addr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkAddr == statAddr && statBits[0]) |-> !chkAllow);
endmodule

// File: tb/sim_flk_lockmgr.sv
module sim_flk_lockmgr;
  localparam int NB = 135;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [21:0] cmdAddr = '0;
  logic        guardN = 1'b1;
  logic        vppOk = 1'b1;
  logic [21:0] chkAddr = '0;
  logic        chkAllow;
  logic [21:0] statAddr = '0;
  logic [1:0]  statBits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [21:0] addr;
    bit          allow;
    bit [1:0]    stat;
    string       tag;
  } item_t;
  item_t sbq[$];

  bit mLock [NB];
  bit mDown [NB];

  always #4 clk = ~clk;

  flk_lockmgr u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .guardN(guardN), .vppOk(vppOk), .chkAddr(chkAddr), .chkAllow(chkAllow),
    .statAddr(statAddr), .statBits(statBits)
  );

  function automatic int blk(logic [21:0] a);
    if (a[21:15] == 7'h7F) return 127 + int'(a[14:12]);
    return int'(a[21:15]);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NB; i++) begin
      mLock[i] = 1'b1;
      mDown[i] = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic issue(input logic [1:0] op, input logic [21:0] a);
    int b;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a;
    b = blk(a);
    if (!(mDown[b] && !guardN)) begin
      if (op == 2'd1) mLock[b] = 1'b1;
      if (op == 2'd2) mLock[b] = 1'b0;
      if (op == 2'd3) begin mLock[b] = 1'b1; mDown[b] = 1'b1; end
    end
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic probe(input logic [21:0] a, input string tag);
    item_t it;
    int b;
    @(negedge clk);
    chkAddr = a; statAddr = a;
    b = blk(a);
    it.addr  = a;
    it.allow = vppOk && !mLock[b] && !(mDown[b] && !guardN);
    it.stat  = {mDown[b], mLock[b]};
    it.tag   = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares after outputs settle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (chkAllow !== it.allow) begin
          fails++;
          $display("FAIL %s allow @%h actual=%b expected=%b", it.tag, it.addr, chkAllow, it.allow);
        end
        checks++;
        if (statBits !== it.stat) begin
          fails++;
          $display("FAIL %s status @%h actual=%b expected=%b", it.tag, it.addr, statBits, it.stat);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();
    // R1 reset state
    probe(22'h000000, "R1");
    probe(22'h3FF000, "R1");
    probe(22'h123456, "R1");
    // R2 unlock/lock, nop
    issue(2'd2, 22'h000010);
    probe(22'h000000, "R2");
    probe(22'h008000, "R9");
    issue(2'd0, 22'h000010);
    probe(22'h007FFF, "R2");
    // R9 boundaries between main and parameter slots
    issue(2'd2, 22'h3F8123);
    probe(22'h3F8FFF, "R9");
    probe(22'h3F9000, "R9");
    probe(22'h3F7FFF, "R9");
    issue(2'd2, 22'h3FFFFF);
    probe(22'h3FF000, "R9");
    probe(22'h3FE000, "R9");
    // R8 voltage lockout
    @(negedge clk); vppOk = 1'b0;
    probe(22'h000000, "R8");
    probe(22'h3F8000, "R8");
    @(negedge clk); vppOk = 1'b1;
    probe(22'h000000, "R8");
    issue(2'd1, 22'h000000);
    probe(22'h000000, "R2");
    // R3 lock-down with pin low, R5 frozen
    @(negedge clk); guardN = 1'b0;
    issue(2'd3, 22'h010000);
    probe(22'h010000, "R3");
    issue(2'd2, 22'h010000);
    probe(22'h010000, "R5");
    // R6 pin high: unlock, relock, unlock
    @(negedge clk); guardN = 1'b1;
    issue(2'd2, 22'h010000);
    probe(22'h010000, "R6");
    issue(2'd1, 22'h010000);
    probe(22'h010000, "R6");
    issue(2'd2, 22'h010000);
    probe(22'h010000, "R4");
    // R3 lock-down of an unlocked block sets lock bit too
    issue(2'd3, 22'h3F8000);
    probe(22'h3F8000, "R3");
    // R7 pin low again restores protection
    @(negedge clk); guardN = 1'b0;
    probe(22'h010000, "R7");
    probe(22'h3F9000, "R7");
    issue(2'd1, 22'h010000);
    probe(22'h010000, "R5");
    // R1 reset wipes lock-down
    doReset();
    probe(22'h010000, "R1");
    probe(22'h3F8000, "R1");
    @(negedge clk); guardN = 1'b1;
    probe(22'h3F9000, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule